// File: doc/BRIEF.md
# Dual-Bank BCD Clock/Calendar Core

This block keeps time of day and calendar date in two register banks. A counting bank advances once for every one-second tick while the oscillator enable is high. A host-visible bank is what the bus side reads. Each cycle the host-visible bank is refreshed from the counting bank, unless the host raises a freeze input. While the freeze is high, the values the host reads stay fixed and counting carries on underneath.

Time is held in 24-hour form as seconds, minutes and hours. The date is held as day of week, day of month, month and a two-digit year, with month lengths and leap Februaries handled. Every field is an 8-bit BCD value. The host changes one field at a time through a select, a data byte and a write enable. A write lands in both banks at the same clock edge, so counting continues from the written value.

Top module: `rtc_dual_bank`

## Requirements
- R1: After reset both banks hold 00:00:00, day of week 01, date 01, month 01, year 00.
- R2: When `osc_en` and `tick_1hz` are high at a clock edge and no field write is made, the counting bank advances by one second. Seconds and minutes roll from 59 to 00, and hours roll from 23 to 00, each carrying into the next field. With `hold` low, the host-visible bank shows the new value one clock later.
- R3: While `osc_en` is low, ticks are ignored and no field changes.
- R4: While `hold` is high, the host-visible bank keeps its values and the counting bank keeps advancing. On the first clock edge with `hold` low, the host-visible bank is reloaded from the counting bank.
- R5: A write (`wr_en` high with `wr_sel` from 0 to 6) stores `wr_data` into the selected field of both banks at that edge, whatever the state of `hold`. A tick in the same cycle is dropped. Later ticks count on from the written value.
- R6: Day of week runs 01 to 07 and steps from 07 back to 01 when the hour wraps past midnight.
- R7: Date rolls to 01 and month advances after the last day of the month. Months 04, 06, 09 and 11 have 30 days, and February is covered by R8. All other months have 31 days. After December the month goes to 01 and the year advances, and year 99 goes to 00.
- R8: February has 29 days when the two-digit year's value is divisible by 4 (00 included), and 28 days otherwise.
- R9: Field select code 7 addresses no field. A write with that code changes nothing and does not block a tick. Codes: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| osc_en | input | 1 | Enables counting |
| hold | input | 1 | Freezes refresh of the host-visible bank |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code (see R9) |
| wr_data | input | 8 | BCD value to write |
| ext_sec | output | 8 | Host-visible seconds |
| ext_min | output | 8 | Host-visible minutes |
| ext_hour | output | 8 | Host-visible hours |
| ext_dow | output | 8 | Host-visible day of week |
| ext_date | output | 8 | Host-visible day of month |
| ext_month | output | 8 | Host-visible month |
| ext_year | output | 8 | Host-visible year |

## Verification
A wrong value in the counting bank reaches the ports one clock after it forms, as long as `hold` is low. The same wrong value stays hidden for the whole freeze and appears on the first clock after release. Carry faults show only on the tick that crosses a boundary. The bench therefore presets each field next to a rollover and checks every output field one clock after that single tick. Freeze faults are found by comparing the frozen outputs with the value expected after release.

// File: rtl/rtc_dual_bank.sv
module rtc_dual_bank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       osc_en,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ext_sec,
  output logic [7:0] ext_min,
  output logic [7:0] ext_hour,
  output logic [7:0] ext_dow,
  output logic [7:0] ext_date,
  output logic [7:0] ext_month,
  output logic [7:0] ext_year
);
  localparam int NF = 7;

  logic [7:0] cur [NF];
  logic [7:0] ext [NF];
  logic [7:0] nxt [NF];
  logic [7:0] int_sec, int_dow;
  logic       wr_hit, step;
  logic       w_sec, w_min, w_hour, w_date, w_mon;
  logic [6:0] yr_bin;
  logic       leap;
  logic [7:0] last_day;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] reset_val(input int i);
    return (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00;
  endfunction

  assign wr_hit = wr_en && (wr_sel != 3'd7);
  assign step   = osc_en && tick_1hz && !wr_hit;

  assign yr_bin = 7'(cur[6][7:4]) * 7'd10 + 7'(cur[6][3:0]);
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (cur[5])
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign w_sec  = (cur[0] == 8'h59);
  assign w_min  = w_sec && (cur[1] == 8'h59);
  assign w_hour = w_min && (cur[2] == 8'h23);
  assign w_date = w_hour && (cur[4] == last_day);
  assign w_mon  = w_date && (cur[5] == 8'h12);

  always_comb begin
    nxt[0] = w_sec ? 8'h00 : bcd_inc(cur[0]);
    nxt[1] = !w_sec ? cur[1] : (cur[1] == 8'h59) ? 8'h00 : bcd_inc(cur[1]);
    nxt[2] = !w_min ? cur[2] : (cur[2] == 8'h23) ? 8'h00 : bcd_inc(cur[2]);
    nxt[3] = !w_hour ? cur[3] : (cur[3] == 8'h07) ? 8'h01 : bcd_inc(cur[3]);
    nxt[4] = !w_hour ? cur[4] : (cur[4] == last_day) ? 8'h01 : bcd_inc(cur[4]);
    nxt[5] = !w_date ? cur[5] : (cur[5] == 8'h12) ? 8'h01 : bcd_inc(cur[5]);
    nxt[6] = !w_mon ? cur[6] : (cur[6] == 8'h99) ? 8'h00 : bcd_inc(cur[6]);
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur[i] <= reset_val(i);
        ext[i] <= reset_val(i);
      end else begin
        if (wr_hit && wr_sel == 3'(i)) cur[i] <= wr_data;
        else if (step)                 cur[i] <= nxt[i];
        if (wr_hit && wr_sel == 3'(i)) ext[i] <= wr_data;
        else if (!hold)                ext[i] <= cur[i];
      end
    end
  end

  assign int_sec   = cur[0];
  assign int_dow   = cur[3];
  assign ext_sec   = ext[0];
  assign ext_min   = ext[1];
  assign ext_hour  = ext[2];
  assign ext_dow   = ext[3];
  assign ext_date  = ext[4];
  assign ext_month = ext[5];
  assign ext_year  = ext[6];
endmodule

module rtc_dual_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       osc_en,
  input logic       hold,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] ext_sec,
  input logic [7:0] ext_dow,
  input logic [7:0] int_sec,
  input logic [7:0] int_dow
);
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (int_sec == 8'h00 && ext_sec == 8'h00 && int_dow == 8'h01));

  a_r2_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && tick_1hz && !wr_en && int_sec != 8'h59) |=> (int_sec != $past(int_sec)));

  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !wr_en) |=> ($stable(int_sec) && $stable(int_dow)));

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> ($stable(ext_sec) && $stable(ext_dow)));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_en) |=> (ext_sec == $past(int_sec) && ext_dow == $past(int_dow)));

  a_r5_write_both: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> (int_sec == $past(wr_data) && ext_sec == $past(wr_data)));

  a_r9_null_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd7 && !(osc_en && tick_1hz)) |=> ($stable(int_sec) && $stable(int_dow)));
endmodule

bind rtc_dual_bank rtc_dual_bank_chk chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_en(osc_en), .hold(hold),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ext_sec(ext_sec),
  .ext_dow(ext_dow), .int_sec(int_sec), .int_dow(int_dow)
);

// File: tb/rtc_dual_bank_test.sv
module rtc_dual_bank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, osc_en = 1, hold = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ext_sec, ext_min, ext_hour, ext_dow, ext_date, ext_month, ext_year;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_dual_bank uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .osc_en(osc_en), .hold(hold),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_sec(ext_sec), .ext_min(ext_min), .ext_hour(ext_hour), .ext_dow(ext_dow),
    .ext_date(ext_date), .ext_month(ext_month), .ext_year(ext_year)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d, logic with_tick = 0);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d; tick = with_tick;
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic set_all(logic [7:0] s, m, h, dw, dt, mo, yr);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  task automatic t_reset;
    chk("R1 sec", ext_sec, 8'h00);   chk("R1 min", ext_min, 8'h00);
    chk("R1 hour", ext_hour, 8'h00); chk("R1 dow", ext_dow, 8'h01);
    chk("R1 date", ext_date, 8'h01); chk("R1 month", ext_month, 8'h01);
    chk("R1 year", ext_year, 8'h00);
  endtask

  task automatic t_simple_tick;
    set_all(8'h09, 8'h10, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30);
    pulse;
    chk("R2 sec bcd step", ext_sec, 8'h10);
    chk("R2 min unchanged", ext_min, 8'h10);
  endtask

  task automatic t_full_rollover;
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    pulse;
    chk("R2 sec wrap", ext_sec, 8'h00);  chk("R2 min wrap", ext_min, 8'h00);
    chk("R2 hour wrap", ext_hour, 8'h00); chk("R6 dow wrap", ext_dow, 8'h01);
    chk("R7 date wrap", ext_date, 8'h01); chk("R7 month wrap", ext_month, 8'h01);
    chk("R7 year wrap", ext_year, 8'h00);
  endtask

  task automatic t_dow_step;
    set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h10, 8'h01, 8'h05);
    pulse;
    chk("R6 dow step", ext_dow, 8'h04);
    chk("R7 date step", ext_date, 8'h11);
  endtask

  task automatic t_month_len;
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h05);
    pulse;
    chk("R7 30-day date", ext_date, 8'h01); chk("R7 30-day month", ext_month, 8'h05);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h05);
    pulse;
    chk("R7 31-day date", ext_date, 8'h31); chk("R7 31-day month", ext_month, 8'h05);
  endtask

  task automatic t_feb(logic [7:0] yr, logic is_leap);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, yr);
    pulse;
    chk("R8 feb28 next date", ext_date, is_leap ? 8'h29 : 8'h01);
    chk("R8 feb28 next month", ext_month, is_leap ? 8'h02 : 8'h03);
    if (is_leap) begin
      wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23);
      pulse;
      chk("R8 feb29 next date", ext_date, 8'h01);
      chk("R8 feb29 next month", ext_month, 8'h03);
    end
  endtask

  task automatic t_osc_off;
    set_all(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    osc_en = 0;
    pulse; pulse; pulse;
    chk("R3 sec frozen", ext_sec, 8'h20);
    osc_en = 1;
    pulse;
    chk("R3 resumes", ext_sec, 8'h21);
  endtask

  task automatic t_hold;
    set_all(8'h40, 8'h12, 8'h08, 8'h02, 8'h05, 8'h03, 8'h11);
    @(negedge clk); hold = 1;
    pulse; pulse; pulse;
    chk("R4 held sec", ext_sec, 8'h40);
    wr(1, 8'h33);
    chk("R5 write while held", ext_min, 8'h33);
    chk("R4 held sec after write", ext_sec, 8'h40);
    hold = 0;
    @(negedge clk);
    chk("R4 reload sec", ext_sec, 8'h43);
    chk("R4 reload min", ext_min, 8'h33);
  endtask

  task automatic t_write_tick;
    set_all(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h10, 1);
    chk("R5 write beats tick", ext_sec, 8'h10);
    @(negedge clk);
    chk("R5 no late advance", ext_sec, 8'h10);
    pulse;
    chk("R5 count from write", ext_sec, 8'h11);
  endtask

  task automatic t_null_sel;
    set_all(8'h25, 8'h44, 8'h13, 8'h05, 8'h17, 8'h08, 8'h42);
    wr(7, 8'h99);
    @(negedge clk);
    chk("R9 sec", ext_sec, 8'h25);   chk("R9 min", ext_min, 8'h44);
    chk("R9 hour", ext_hour, 8'h13); chk("R9 dow", ext_dow, 8'h05);
    chk("R9 date", ext_date, 8'h17); chk("R9 month", ext_month, 8'h08);
    chk("R9 year", ext_year, 8'h42);
    wr(7, 8'h00, 1);
    @(negedge clk);
    chk("R9 tick not blocked", ext_sec, 8'h26);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_simple_tick;
    t_full_rollover;
    t_dow_step;
    t_month_len;
    t_feb(8'h24, 1);
    t_feb(8'h00, 1);
    t_feb(8'h10, 0);
    t_feb(8'h23, 0);
    t_osc_off;
    t_hold;
    t_write_tick;
    t_null_sel;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule